// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Monitor

This block sits beside a two-bank single-data-rate SDRAM and observes the control pins on each rising clock edge. It turns the chip select, row strobe, column strobe, write enable and clock enable levels into one command per edge. It keeps a model of each bank: idle, open, bursting, bursting with automatic precharge, or recovering after an automatic precharge. When a command arrives in a state that does not allow it, the block reports a one-cycle violation with an error code. The command is then dropped from the model, so it changes no bank state.

It also produces two data-mask outputs from the mask pin. One marks write data slots that are masked, with no delay. The other marks read data slots that are held at high impedance, two edges after the mask was sampled. All outputs are registered. The values seen in the cycle after edge n describe the command sampled at edge n. Burst length and row-precharge recovery time are parameters. The burst length is reloaded by every legal mode register set.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When chip select is low and the previous edge saw clock enable high, the pins row/column/write decode as follows. 000 is mode set (cmd_o 1), 001 is refresh (2), 011 is activate (5), 101 is read (6), 100 is write (7), 110 is burst stop (8), 010 is precharge (9) and 111 is no operation (0). Chip select high always gives no operation. A no operation never raises a violation.
- R2: A refresh with clock enable high at this edge is an auto refresh (2). A refresh with clock enable dropping from high to low enters self refresh (3). Edges that follow an edge with clock enable low are ignored (cmd_o 0). The exception is self refresh: the first edge with clock enable back high is reported as the exit (4).
- R3: For activate, read, write and precharge, ba 0 selects bank A and ba 1 selects bank B. A precharge with ap high closes both banks whatever ba is. A precharge of an idle bank is legal and changes nothing.
- R4: Activate is legal only on an idle bank. An activate on an open or bursting bank gives error 7.
- R5: A read or write to an open bank starts a burst of BL cycles and captures addr[8:0] on col_o. A read or write to an idle or recovering bank gives error 5, and col_o is left unchanged.
- R6: A read or write with ap high starts an auto-precharge burst. While that burst runs, any read or write gives error 3. After the burst, the bank recovers for TRP cycles. An activate to that bank before TRP cycles have passed gives error 4.
- R7: Mode set, auto refresh and self-refresh entry need both banks idle, or they give error 1 and are not carried out. A legal mode set loads the burst length from addr[2:0]: 0 gives 1, 1 gives 2, 2 gives 4, and any other code gives 8. Reset restores BL_DEFAULT.
- R8: Any command other than no operation on the two edges after a legal mode set gives error 2.
- R9: Burst stop ends the running burst: a plain burst returns its bank to open, and an auto-precharge burst goes to recovery. A burst stop when no burst runs gives error 6.
- R10: wr_mask_o after edge n equals dqm sampled at edge n. rd_hiz_o after edge n equals dqm sampled at edge n-2.
- R11: Outputs are registered, one cycle after the edge. viol_o is high exactly when err_o is nonzero. An illegal command leaves every bank state unchanged. Bank state codes are idle 0, open 1, burst 2, auto-precharge burst 3 and recovery 4, with bank A in bank_state_o[2:0]. Reset clears all outputs and bank states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask pin |
| ba | input | 1 | Bank select |
| ap | input | 1 | Auto precharge / all-banks address line |
| addr | input | 9 | Low address lines (column, mode code) |
| cmd_o | output | 4 | Decoded command of the last edge |
| viol_o | output | 1 | Violation pulse for the last edge |
| err_o | output | 3 | Error code of the last edge |
| bank_state_o | output | 6 | State of bank B (upper) and bank A (lower) |
| bl_o | output | 4 | Current burst length |
| col_o | output | 9 | Column of the last legal read or write |
| wr_mask_o | output | 1 | Write data slot masked |
| rd_hiz_o | output | 1 | Read data slot at high impedance |

## Verification
The decoder is driven with every pin combination, with chip select held high, and with clock-enable transitions. These patterns separate auto refresh from self-refresh entry and show that ignored edges are not decoded. A scripted command stream moves both banks through open, plain burst, auto-precharge burst and recovery. It places commands on the exact edge where a burst ends and one edge before recovery finishes, so off-by-one errors in the counters show up as wrong error codes. A single mask pulse separates the zero-latency write mask from the two-edge read mask. A mode set followed at once by activates shows both the hold window and the change in burst length.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    localparam int NUM_BANKS = 2;
    localparam int MAX_BL    = 8;
    localparam int MRS_GAP   = 2;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_MRS      = 4'd1,
        CMD_AREF     = 4'd2,
        CMD_SREF_IN  = 4'd3,
        CMD_SREF_OUT = 4'd4,
        CMD_ACT      = 4'd5,
        CMD_RD       = 4'd6,
        CMD_WR       = 4'd7,
        CMD_BST      = 4'd8,
        CMD_PRE      = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE     = 3'd0,
        BK_OPEN     = 3'd1,
        BK_BURST    = 3'd2,
        BK_BURST_AP = 3'd3,
        BK_RECOVER  = 3'd4
    } bank_e;

    typedef enum logic [2:0] {
        ERR_NONE         = 3'd0,
        ERR_BUSY_BANKS   = 3'd1,
        ERR_MRS_HOLD     = 3'd2,
        ERR_AP_LOCK      = 3'd3,
        ERR_TRP          = 3'd4,
        ERR_CLOSED       = 3'd5,
        ERR_NO_BURST     = 3'd6,
        ERR_ALREADY_OPEN = 3'd7
    } err_e;

    // Strobe decode for an edge where the command is taken (chip selected)
    function automatic cmd_e pin_cmd(input logic ras_n, input logic cas_n, input logic we_n);
        case ({ras_n, cas_n, we_n})
            3'b000:  return CMD_MRS;
            3'b001:  return CMD_AREF;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b110:  return CMD_BST;
            3'b010:  return CMD_PRE;
            default: return CMD_NOP;
        endcase
    endfunction

    // Mode code to burst length
    function automatic logic [3:0] bl_from_code(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
    import sdcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic sref_ok,
    output cmd_e cmd
);
    logic cke_q;
    logic in_sref_q;

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_q) begin
            if (in_sref_q && cke) cmd = CMD_SREF_OUT;
        end else if (!cs_n) begin
            cmd = pin_cmd(ras_n, cas_n, we_n);
            if (cmd == CMD_AREF && !cke) cmd = CMD_SREF_IN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q     <= 1'b1;
            in_sref_q <= 1'b0;
        end else begin
            cke_q <= cke;
            if (sref_ok)                 in_sref_q <= 1'b1;
            else if (cmd == CMD_SREF_OUT) in_sref_q <= 1'b0;
        end
    end

    // R2: while clock enable stays low, nothing but the self-refresh exit can decode
    p_suspend_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!cke_q && cmd != CMD_NOP) |-> (cmd == CMD_SREF_OUT && in_sref_q));

endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
    import sdcm_pkg::*;
#(
    parameter int TRP = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bl,
    input  logic       go_act,
    input  logic       go_burst,
    input  logic       go_ap,
    input  logic       go_close,
    input  logic       go_stop,
    output bank_e      eff_o,
    output bank_e      state_o
);
    localparam int CNT_W = $clog2(MAX_BL);
    localparam int TRP_W = $clog2(TRP + 1);

    bank_e            state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TRP_W-1:0] rcnt_q;

    // State as seen by a command at this edge: expired counters already applied
    always_comb begin
        case (state_q)
            BK_BURST:    eff_o = (cnt_q == '0)  ? BK_OPEN    : BK_BURST;
            BK_BURST_AP: eff_o = (cnt_q == '0)  ? BK_RECOVER : BK_BURST_AP;
            BK_RECOVER:  eff_o = (rcnt_q == '0) ? BK_IDLE    : BK_RECOVER;
            default:     eff_o = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            rcnt_q  <= '0;
        end else begin
            state_q <= eff_o;
            if (cnt_q != '0)  cnt_q  <= cnt_q - 1'b1;
            if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
            if (state_q == BK_BURST_AP && cnt_q == '0) rcnt_q <= TRP_W'(TRP - 1);

            if (go_act) begin
                state_q <= BK_OPEN;
            end else if (go_burst) begin
                state_q <= go_ap ? BK_BURST_AP : BK_BURST;
                cnt_q   <= CNT_W'(bl - 4'd1);
            end else if (go_close) begin
                state_q <= BK_IDLE;
            end else if (go_stop) begin
                if (eff_o == BK_BURST) begin
                    state_q <= BK_OPEN;
                end else if (eff_o == BK_BURST_AP) begin
                    state_q <= BK_RECOVER;
                    rcnt_q  <= TRP_W'(TRP - 1);
                end
            end
        end
    end

    assign state_o = state_q;

    // R6: an auto-precharge burst is only cut short by a burst stop
    p_ap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == BK_BURST_AP && cnt_q != '0 && !go_stop) |=> state_q == BK_BURST_AP);

    // R6: a recovering bank cannot be reopened before its counter expires
    p_recover_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == BK_RECOVER && rcnt_q != '0) |=> state_q == BK_RECOVER);

endmodule

// File: rtl/sdcm_dqm.sv
module sdcm_dqm #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dqm,
    output logic wr_mask_o,
    output logic rd_hiz_o
);
    localparam int QW = $clog2(RD_LAT + 2);

    logic [RD_LAT:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q[0] <= 1'b0;
        else     pipe_q[0] <= dqm;
    end

    for (genvar s = 1; s <= RD_LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe_q[s] <= 1'b0;
            else     pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign wr_mask_o = pipe_q[0];
    assign rd_hiz_o  = pipe_q[RD_LAT];

    // Checker: edges since the mask pin was last sampled high
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst)                           quiet_q <= QW'(RD_LAT + 1);
        else if (dqm)                      quiet_q <= '0;
        else if (quiet_q != QW'(RD_LAT + 1)) quiet_q <= quiet_q + 1'b1;
    end

    p_rd_hiz_on_r10: assert property (@(posedge clk) disable iff (rst)
        (quiet_q == QW'(RD_LAT)) |-> rd_hiz_o);
    p_rd_hiz_off_r10: assert property (@(posedge clk) disable iff (rst)
        (quiet_q > QW'(RD_LAT)) |-> !rd_hiz_o);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int BL_DEFAULT = 4,
    parameter int TRP        = 3,
    parameter int RD_LAT     = 2,
    parameter int COL_W      = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   dqm,
    input  logic                   ba,
    input  logic                   ap,
    input  logic [COL_W-1:0]       addr,
    output logic [3:0]             cmd_o,
    output logic                   viol_o,
    output logic [2:0]             err_o,
    output logic [3*NUM_BANKS-1:0] bank_state_o,
    output logic [3:0]             bl_o,
    output logic [COL_W-1:0]       col_o,
    output logic                   wr_mask_o,
    output logic                   rd_hiz_o
);
    localparam int GW = $clog2(MRS_GAP + 1);

    cmd_e  cmd;
    err_e  err;
    logic  ok;
    logic  sref_ok;
    logic  any_ap, any_burst, both_idle, rw;
    bank_e eff   [NUM_BANKS];
    bank_e state [NUM_BANKS];

    logic [GW-1:0]   guard_q;
    logic [3:0]      bl_q;
    cmd_e            cmd_q;
    err_e            err_q;
    logic            viol_q;
    logic [COL_W-1:0] col_q;

    sdcm_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .cke     (cke),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .sref_ok (sref_ok),
        .cmd     (cmd)
    );

    // Legality of the command at this edge
    always_comb begin
        any_ap    = (eff[0] == BK_BURST_AP) || (eff[1] == BK_BURST_AP);
        any_burst = any_ap || (eff[0] == BK_BURST) || (eff[1] == BK_BURST);
        both_idle = (eff[0] == BK_IDLE) && (eff[1] == BK_IDLE);
        rw        = (cmd == CMD_RD) || (cmd == CMD_WR);
        err       = ERR_NONE;
        if (guard_q != '0 && cmd != CMD_NOP) begin
            err = ERR_MRS_HOLD;
        end else begin
            case (cmd)
                CMD_MRS, CMD_AREF, CMD_SREF_IN:
                    if (!both_idle) err = ERR_BUSY_BANKS;
                CMD_ACT:
                    if (eff[ba] == BK_RECOVER)   err = ERR_TRP;
                    else if (eff[ba] != BK_IDLE) err = ERR_ALREADY_OPEN;
                CMD_RD, CMD_WR:
                    if (any_ap) err = ERR_AP_LOCK;
                    else if (eff[ba] != BK_OPEN && eff[ba] != BK_BURST) err = ERR_CLOSED;
                CMD_BST:
                    if (!any_burst) err = ERR_NO_BURST;
                default: err = ERR_NONE;
            endcase
        end
        ok      = (err == ERR_NONE);
        sref_ok = ok && (cmd == CMD_SREF_IN);
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (int'(ba) == g);

        sdcm_bank #(.TRP(TRP)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .bl       (bl_q),
            .go_act   (ok && cmd == CMD_ACT && hit),
            .go_burst (ok && rw && hit),
            .go_ap    (ap),
            .go_close (ok && cmd == CMD_PRE && (ap || hit) &&
                       (eff[g] == BK_OPEN || eff[g] == BK_BURST)),
            .go_stop  (ok && (cmd == CMD_BST || (rw && !hit))),
            .eff_o    (eff[g]),
            .state_o  (state[g])
        );

        assign bank_state_o[3*g +: 3] = state[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            guard_q <= '0;
            bl_q    <= 4'(BL_DEFAULT);
            cmd_q   <= CMD_NOP;
            err_q   <= ERR_NONE;
            viol_q  <= 1'b0;
            col_q   <= '0;
        end else begin
            if (ok && cmd == CMD_MRS) begin
                guard_q <= GW'(MRS_GAP);
                bl_q    <= bl_from_code(addr[2:0]);
            end else if (guard_q != '0) begin
                guard_q <= guard_q - 1'b1;
            end
            if (ok && rw) col_q <= addr;
            cmd_q  <= cmd;
            err_q  <= err;
            viol_q <= !ok;
        end
    end

    sdcm_dqm #(.RD_LAT(RD_LAT)) u_dqm (
        .clk       (clk),
        .rst       (rst),
        .dqm       (dqm),
        .wr_mask_o (wr_mask_o),
        .rd_hiz_o  (rd_hiz_o)
    );

    assign cmd_o = cmd_q;
    assign err_o = err_q;
    assign viol_o = viol_q;
    assign bl_o  = bl_q;
    assign col_o = col_q;

    // R1: a no operation is never reported as a violation
    p_nop_clean_r1: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> cmd_o != CMD_NOP);

    // R11: the violation flag and the error code agree
    p_viol_code_r11: assert property (@(posedge clk) disable iff (rst)
        viol_o == (err_o != ERR_NONE));

    // R8: a real command right after a legal mode set is flagged
    p_mrs_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_o == CMD_MRS && !viol_o) && cmd_o != CMD_NOP) |-> viol_o);

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic dqm = 1'b0, ba = 1'b0, ap = 1'b0;
    logic [8:0] addr = '0;
    logic [3:0] cmd_o;
    logic       viol_o;
    logic [2:0] err_o;
    logic [5:0] bank_state_o;
    logic [3:0] bl_o;
    logic [8:0] col_o;
    logic       wr_mask_o, rd_hiz_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .ap(ap), .addr(addr),
        .cmd_o(cmd_o), .viol_o(viol_o), .err_o(err_o), .bank_state_o(bank_state_o),
        .bl_o(bl_o), .col_o(col_o), .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o)
    );

    // strobe codes {ras_n,cas_n,we_n}
    localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011, P_RD = 3'b101,
                           P_WR = 3'b100, P_BST = 3'b110, P_PRE = 3'b010, P_NOP = 3'b111;

    typedef struct packed {
        logic       cs_n;
        logic [2:0] pins;
        logic       ba;
        logic       ap;
        logic [2:0] a;
        logic [3:0] cmd;
        logic [2:0] err;
        logic [2:0] sa;
        logic [2:0] sb;
    } vec_t;

    // Command script: BL 4, TRP 3 at start
    localparam vec_t VECS [0:39] = '{
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd0, 3'd0},
        '{1'b0, P_ACT, 1'b0, 1'b0, 3'd0, 4'd5, 3'd0, 3'd1, 3'd0},
        '{1'b0, P_ACT, 1'b0, 1'b0, 3'd0, 4'd5, 3'd7, 3'd1, 3'd0},
        '{1'b0, P_RD,  1'b0, 1'b0, 3'd0, 4'd6, 3'd0, 3'd2, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd2, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd2, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd2, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd1, 3'd0},
        '{1'b0, P_RD,  1'b1, 1'b0, 3'd0, 4'd6, 3'd5, 3'd1, 3'd0},
        '{1'b0, P_ACT, 1'b1, 1'b0, 3'd0, 4'd5, 3'd0, 3'd1, 3'd1},
        '{1'b0, P_WR,  1'b1, 1'b1, 3'd0, 4'd7, 3'd0, 3'd1, 3'd3},
        '{1'b0, P_RD,  1'b0, 1'b0, 3'd0, 4'd6, 3'd3, 3'd1, 3'd3},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd1, 3'd3},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd1, 3'd3},
        '{1'b0, P_ACT, 1'b1, 1'b0, 3'd0, 4'd5, 3'd4, 3'd1, 3'd4},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd1, 3'd4},
        '{1'b0, P_ACT, 1'b1, 1'b0, 3'd0, 4'd5, 3'd4, 3'd1, 3'd4},
        '{1'b0, P_RD,  1'b0, 1'b0, 3'd0, 4'd6, 3'd0, 3'd2, 3'd0},
        '{1'b0, P_ACT, 1'b1, 1'b0, 3'd0, 4'd5, 3'd0, 3'd2, 3'd1},
        '{1'b0, P_PRE, 1'b0, 1'b1, 3'd0, 4'd9, 3'd0, 3'd0, 3'd0},
        '{1'b0, P_MRS, 1'b0, 1'b0, 3'd1, 4'd1, 3'd0, 3'd0, 3'd0},
        '{1'b0, P_ACT, 1'b0, 1'b0, 3'd0, 4'd5, 3'd2, 3'd0, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd0, 3'd0},
        '{1'b0, P_ACT, 1'b0, 1'b0, 3'd0, 4'd5, 3'd0, 3'd1, 3'd0},
        '{1'b0, P_REF, 1'b0, 1'b0, 3'd0, 4'd2, 3'd1, 3'd1, 3'd0},
        '{1'b0, P_RD,  1'b0, 1'b0, 3'd0, 4'd6, 3'd0, 3'd2, 3'd0},
        '{1'b0, P_BST, 1'b0, 1'b0, 3'd0, 4'd8, 3'd0, 3'd1, 3'd0},
        '{1'b0, P_BST, 1'b0, 1'b0, 3'd0, 4'd8, 3'd6, 3'd1, 3'd0},
        '{1'b0, P_WR,  1'b0, 1'b1, 3'd0, 4'd7, 3'd0, 3'd3, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd3, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd4, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd4, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd4, 3'd0},
        '{1'b0, P_NOP, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd0, 3'd0},
        '{1'b0, P_ACT, 1'b0, 1'b0, 3'd0, 4'd5, 3'd0, 3'd1, 3'd0},
        '{1'b0, P_ACT, 1'b1, 1'b0, 3'd0, 4'd5, 3'd0, 3'd1, 3'd1},
        '{1'b0, P_PRE, 1'b1, 1'b0, 3'd0, 4'd9, 3'd0, 3'd1, 3'd0},
        '{1'b0, P_PRE, 1'b0, 1'b0, 3'd0, 4'd9, 3'd0, 3'd0, 3'd0},
        '{1'b1, P_MRS, 1'b0, 1'b0, 3'd0, 4'd0, 3'd0, 3'd0, 3'd0},
        '{1'b0, P_PRE, 1'b0, 1'b0, 3'd0, 4'd9, 3'd0, 3'd0, 3'd0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge
    task automatic step(input logic c, input logic [2:0] p, input logic b, input logic a_p,
                        input logic [8:0] ad, input logic m, input logic k);
        cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; ap = a_p; addr = ad; dqm = m; cke = k;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", "reset cmd", 32'(cmd_o), 0);
        chk("R11", "reset viol", 32'(viol_o), 0);
        chk("R11", "reset banks", 32'(bank_state_o), 0);
        chk("R7", "reset burst length", 32'(bl_o), 4);
        chk("R10", "reset masks", 32'({wr_mask_o, rd_hiz_o}), 0);

        // R1 R3 R4 R5 R6 R7 R8 R9 R11 scripted stream
        for (int i = 0; i < 40; i++) begin
            step(VECS[i].cs_n, VECS[i].pins, VECS[i].ba, VECS[i].ap,
                 9'(VECS[i].a), 1'b0, 1'b1);
            chk("R1", $sformatf("row %0d cmd", i), 32'(cmd_o), 32'(VECS[i].cmd));
            chk("R6", $sformatf("row %0d err", i), 32'(err_o), 32'(VECS[i].err));
            chk("R11", $sformatf("row %0d viol", i), 32'(viol_o), 32'(VECS[i].err != 0));
            chk("R3", $sformatf("row %0d bank A", i), 32'(bank_state_o[2:0]), 32'(VECS[i].sa));
            chk("R4", $sformatf("row %0d bank B", i), 32'(bank_state_o[5:3]), 32'(VECS[i].sb));
        end
        chk("R7", "burst length after mode set", 32'(bl_o), 2);

        // R10 mask latency: one pulse
        step(1'b0, P_NOP, 1'b0, 1'b0, 9'd0, 1'b1, 1'b1);
        chk("R10", "write mask same edge", 32'({wr_mask_o, rd_hiz_o}), 32'b10);
        step(1'b0, P_NOP, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R10", "read mask edge+1", 32'({wr_mask_o, rd_hiz_o}), 32'b00);
        step(1'b0, P_NOP, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R10", "read mask edge+2", 32'({wr_mask_o, rd_hiz_o}), 32'b01);
        step(1'b0, P_NOP, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R10", "read mask edge+3", 32'({wr_mask_o, rd_hiz_o}), 32'b00);

        // R5 column capture
        step(1'b0, P_ACT, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        step(1'b0, P_RD, 1'b0, 1'b0, 9'h1A5, 1'b0, 1'b1);
        chk("R5", "column captured", 32'(col_o), 32'h1A5);
        step(1'b0, P_WR, 1'b1, 1'b0, 9'h0F0, 1'b0, 1'b1);
        chk("R5", "closed bank error", 32'(err_o), 5);
        chk("R5", "column kept on illegal", 32'(col_o), 32'h1A5);
        step(1'b0, P_PRE, 1'b0, 1'b1, 9'd0, 1'b0, 1'b1);
        chk("R3", "precharge all", 32'(bank_state_o), 0);

        // R2 self refresh entry, ignored edges, exit
        step(1'b0, P_REF, 1'b0, 1'b0, 9'd0, 1'b0, 1'b0);
        chk("R2", "self refresh entry", 32'(cmd_o), 3);
        step(1'b0, P_ACT, 1'b0, 1'b0, 9'd0, 1'b0, 1'b0);
        chk("R2", "ignored edge cmd", 32'(cmd_o), 0);
        chk("R2", "ignored edge bank", 32'(bank_state_o), 0);
        step(1'b0, P_NOP, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R2", "self refresh exit", 32'(cmd_o), 4);
        step(1'b0, P_REF, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R2", "auto refresh", 32'(cmd_o), 2);
        step(1'b0, P_ACT, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R2", "activate after exit", 32'(bank_state_o[2:0]), 1);

        // R7 self refresh entry refused with an open bank
        step(1'b0, P_REF, 1'b0, 1'b0, 9'd0, 1'b0, 1'b0);
        chk("R7", "refused entry code", 32'(err_o), 1);
        step(1'b1, P_NOP, 1'b0, 1'b0, 9'd0, 1'b0, 1'b0);
        step(1'b1, P_NOP, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1);
        chk("R7", "no exit after refused entry", 32'(cmd_o), 0);

        // R7 mode code 7 gives 8, reset restores default
        step(1'b0, P_PRE, 1'b0, 1'b1, 9'd0, 1'b0, 1'b1);
        step(1'b0, P_MRS, 1'b0, 1'b0, 9'd7, 1'b0, 1'b1);
        chk("R7", "mode code 7", 32'(bl_o), 8);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7", "default after reset", 32'(bl_o), 4);
        chk("R11", "banks after reset", 32'(bank_state_o), 0);

        finish_run();
    end
endmodule